// File: doc/BRIEF.md
# DMA External Request Command Handler

This block sits between an external requesting device and a four-channel DMA engine. The device raises a one-cycle request strobe. With the strobe it presents a command made of three fields: a 2-bit channel number, a 2-bit operation field and a 3-bit length field. The handler latches the command and acts on it on the next clock edge. It then answers with a bus-available pulse. That pulse is lengthened to a programmed number of cycles when the DRAM side signals a row miss on a bank that is not precharged.

Most commands place a one-deep pending request in the addressed channel's queue. Two fixed codes are handled specially. One ends channel 0's transfers. The other flushes every queue and can release a frozen engine. A fixed-priority arbiter starts the lowest-numbered channel that is both pending and enabled. It holds the transfer acknowledge until the data path reports completion, and it shows the running channel on a 2-bit output. If the mode-enable input changes while a transfer is running, the handler freezes and all transfers stop.

Top module: `dma_xreq_cmd`

## Requirements
- R1: While reset is high, and on the cycle after it, bus_avail_o, xfer_ack_o, freeze_o, proto_err_o, pend_o and ch_en_o are all zero.
- R2: A request strobe sampled on edge k is acted on at edge k+1. A command that is neither of the two fixed codes (this includes chan=0, op=2, len=5) sets pend_o[chan] and drives bus_avail_o high for exactly one cycle after edge k+1, provided row_miss_i is low at edge k+1.
- R3: If row_miss_i is high at the acting edge, bus_avail_o stays high for prech_cycles_i cycles. A programmed value of 0 acts as 1.
- R4: A command acted on while bus_avail_o is being held by a row miss is dropped. It sets no pending bit and produces no additional bus-available cycles.
- R5: A strobe sampled on the edge right after another strobe was latched is a protocol error. proto_err_o pulses for one cycle, that command is dropped, and the first command still executes.
- R6: The transfer-end command (chan=0, op=0, len=7) is refused while channel 0 is transferring: no pulse and no state change. When accepted, it gives one bus-available cycle and clears ch_en_o[0] and pend_o[0]. Raising ch_en_set_i[0] enables the channel again.
- R7: The flush command (chan=0, op=2, len=6) gives one bus-available cycle and clears every bit of pend_o.
- R8: An accepted flush clears freeze_o only if cmd_mode_en_i is 1 at that edge. Otherwise the freeze stays.
- R9: A change of cmd_mode_en_i in either direction at an edge where a transfer is running sets freeze_o and drops xfer_ack_o on that same edge. No transfer starts while freeze_o is 1.
- R10: When idle and not frozen, the handler starts the lowest-numbered channel whose pending and enable bits are both set. It clears that pending bit, holds xfer_ack_o until xfer_done_i, and starts nothing on the edge where it sees xfer_done_i.
- R11: While xfer_ack_o is high, act_ch_o gives the running channel: 0 encodes channel 0, 1 channel 1, 2 channel 2 and 3 channel 3. The value is stable for the whole transfer. While idle, act_ch_o is 0.
- R12: Each channel holds at most one pending request. Repeated requests to a channel that is already pending lead to a single transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | External request strobe, one cycle per command |
| cmd_chan_i | input | 2 | Command channel field |
| cmd_op_i | input | 2 | Command operation field |
| cmd_len_i | input | 3 | Command length field |
| row_miss_i | input | 1 | DRAM row miss on a non-precharged bank, sampled at the acting edge |
| prech_cycles_i | input | PCW | Programmed precharge hold length in cycles |
| cmd_mode_en_i | input | 1 | Command-mode enable bit |
| ch_en_set_i | input | 4 | Per-channel enable set pulses |
| xfer_done_i | input | 1 | Data path reports the running transfer finished |
| bus_avail_o | output | 1 | Bus-available answer |
| proto_err_o | output | 1 | Protocol error pulse |
| xfer_ack_o | output | 1 | Transfer acknowledge |
| act_ch_o | output | 2 | Running channel number |
| pend_o | output | 4 | Per-channel pending request bits |
| ch_en_o | output | 4 | Per-channel enable bits |
| freeze_o | output | 1 | Freeze state |

## Verification
The properties take four things for granted. The command fields are valid in the cycle the strobe is sampled. xfer_done_i is raised only while a transfer is acknowledged. prech_cycles_i is held steady while a row-miss hold is running. row_miss_i matters only at the edge where a command is acted on. The bench drives all inputs on the falling clock edge and pulses xfer_done_i only after it has seen xfer_ack_o high. It changes the precharge length only between scenarios, and it keeps row_miss_i at the value it set for the most recent command until the next command. Strobes are one cycle wide, except in the one scenario that provokes a protocol error on purpose.

// File: rtl/dxr_pkg.sv
package dxr_pkg;

    localparam int NCH = 4;
    localparam int IDW = $clog2(NCH);
    localparam int OPW = 2;
    localparam int LNW = 3;

    // Fixed command codes
    localparam logic [IDW-1:0] END_CHAN   = '0;
    localparam logic [OPW-1:0] END_OP     = 2'd0;
    localparam logic [LNW-1:0] END_LEN    = 3'd7;
    localparam logic [IDW-1:0] FLUSH_CHAN = '0;
    localparam logic [OPW-1:0] FLUSH_OP   = 2'd2;
    localparam logic [LNW-1:0] FLUSH_LEN  = 3'd6;

    typedef enum logic [1:0] {
        K_NONE,
        K_REQ,
        K_END,
        K_FLUSH
    } cmd_kind_e;

    typedef struct packed {
        logic [IDW-1:0] chan;
        logic [OPW-1:0] op;
        logic [LNW-1:0] len;
    } cmd_t;

    typedef struct packed {
        logic           vld;
        cmd_kind_e      kind;
        logic [IDW-1:0] chan;
    } acc_t;

    function automatic cmd_kind_e classify(input cmd_t c);
        if (c.chan == END_CHAN && c.op == END_OP && c.len == END_LEN)
            return K_END;
        else if (c.chan == FLUSH_CHAN && c.op == FLUSH_OP && c.len == FLUSH_LEN)
            return K_FLUSH;
        else
            return K_REQ;
    endfunction

    function automatic logic [IDW-1:0] lowest(input logic [NCH-1:0] v);
        logic [IDW-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (v[i]) r = IDW'(i);
        return r;
    endfunction

endpackage

// File: rtl/dxr_intake.sv
module dxr_intake
    import dxr_pkg::*;
#(
    parameter int PCW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_i,
    input  cmd_t           cmd_i,
    input  logic           row_miss_i,
    input  logic [PCW-1:0] prech_i,
    input  logic           ch0_busy_i,
    output acc_t           acc_o,
    output logic           bavail_o,
    output logic           perr_o
);

    logic           held_q;
    cmd_t           cmd_q;
    logic [PCW-1:0] hold_cnt;
    logic           miss_q;
    logic           in_hold;
    cmd_kind_e      kind;
    logic           take;

    assign in_hold = miss_q && (hold_cnt != '0);
    assign kind    = classify(cmd_q);
    assign take    = held_q && !in_hold && !(kind == K_END && ch0_busy_i);

    assign acc_o.vld  = take;
    assign acc_o.kind = kind;
    assign acc_o.chan = cmd_q.chan;
    assign bavail_o   = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= 1'b0;
            cmd_q    <= '0;
            hold_cnt <= '0;
            miss_q   <= 1'b0;
            perr_o   <= 1'b0;
        end else begin
            perr_o <= req_i && held_q;
            held_q <= req_i && !held_q;
            if (req_i && !held_q)
                cmd_q <= cmd_i;
            if (take) begin
                miss_q   <= row_miss_i;
                hold_cnt <= (row_miss_i && prech_i != '0) ? prech_i : PCW'(1);
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dxr_queue.sv
module dxr_queue
    import dxr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  acc_t           acc_i,
    input  logic [NCH-1:0] en_set_i,
    input  logic           grant_i,
    input  logic [IDW-1:0] grant_ch_i,
    output logic [NCH-1:0] pend_o,
    output logic [NCH-1:0] en_o
);

    logic is_flush;
    logic is_req;
    logic is_end;

    assign is_flush = acc_i.vld && acc_i.kind == K_FLUSH;
    assign is_req   = acc_i.vld && acc_i.kind == K_REQ;
    assign is_end   = acc_i.vld && acc_i.kind == K_END;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic end_hit;
        assign end_hit = is_end && (g == 0);

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_o[g] <= 1'b0;
                en_o[g]   <= 1'b0;
            end else begin
                if (is_flush)
                    pend_o[g] <= 1'b0;
                else if (is_req && acc_i.chan == IDW'(g))
                    pend_o[g] <= 1'b1;
                else if (end_hit || (grant_i && grant_ch_i == IDW'(g)))
                    pend_o[g] <= 1'b0;

                if (en_set_i[g])
                    en_o[g] <= 1'b1;
                else if (end_hit)
                    en_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dxr_xfer.sv
module dxr_xfer
    import dxr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pend_i,
    input  logic [NCH-1:0] en_i,
    input  logic           done_i,
    input  logic           mode_en_i,
    input  logic           flush_i,
    output logic           grant_o,
    output logic [IDW-1:0] grant_ch_o,
    output logic           active_o,
    output logic [IDW-1:0] cur_o,
    output logic           freeze_o,
    output logic           ch0_busy_o
);

    logic           mode_q;
    logic [NCH-1:0] ready;
    logic           freeze_set;
    logic           unfreeze;

    assign ready      = pend_i & en_i;
    assign freeze_set = active_o && (mode_en_i != mode_q);
    assign unfreeze   = flush_i && mode_en_i;
    assign grant_o    = !active_o && !freeze_o && (|ready);
    assign grant_ch_o = lowest(ready);
    assign ch0_busy_o = active_o && (cur_o == '0);

    always_ff @(posedge clk) begin
        mode_q <= mode_en_i;
        if (rst) begin
            active_o <= 1'b0;
            cur_o    <= '0;
            freeze_o <= 1'b0;
        end else begin
            if (freeze_set)
                freeze_o <= 1'b1;
            else if (unfreeze)
                freeze_o <= 1'b0;

            if (freeze_set) begin
                active_o <= 1'b0;
            end else if (grant_o) begin
                active_o <= 1'b1;
                cur_o    <= grant_ch_o;
            end else if (done_i) begin
                active_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_xreq_cmd.sv
module dma_xreq_cmd
    import dxr_pkg::*;
#(
    parameter int PCW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_i,
    input  logic [1:0]     cmd_chan_i,
    input  logic [1:0]     cmd_op_i,
    input  logic [2:0]     cmd_len_i,
    input  logic           row_miss_i,
    input  logic [PCW-1:0] prech_cycles_i,
    input  logic           cmd_mode_en_i,
    input  logic [3:0]     ch_en_set_i,
    input  logic           xfer_done_i,
    output logic           bus_avail_o,
    output logic           proto_err_o,
    output logic           xfer_ack_o,
    output logic [1:0]     act_ch_o,
    output logic [3:0]     pend_o,
    output logic [3:0]     ch_en_o,
    output logic           freeze_o
);

    cmd_t           cmd;
    acc_t           acc;
    logic           grant;
    logic [IDW-1:0] grant_ch;
    logic           active;
    logic [IDW-1:0] cur;
    logic           ch0_busy;
    logic           flush_acc;

    assign cmd.chan  = cmd_chan_i;
    assign cmd.op    = cmd_op_i;
    assign cmd.len   = cmd_len_i;
    assign flush_acc = acc.vld && acc.kind == K_FLUSH;

    dxr_intake #(.PCW(PCW)) u_intake (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .cmd_i      (cmd),
        .row_miss_i (row_miss_i),
        .prech_i    (prech_cycles_i),
        .ch0_busy_i (ch0_busy),
        .acc_o      (acc),
        .bavail_o   (bus_avail_o),
        .perr_o     (proto_err_o)
    );

    dxr_queue u_queue (
        .clk        (clk),
        .rst        (rst),
        .acc_i      (acc),
        .en_set_i   (ch_en_set_i),
        .grant_i    (grant),
        .grant_ch_i (grant_ch),
        .pend_o     (pend_o),
        .en_o       (ch_en_o)
    );

    dxr_xfer u_xfer (
        .clk        (clk),
        .rst        (rst),
        .pend_i     (pend_o),
        .en_i       (ch_en_o),
        .done_i     (xfer_done_i),
        .mode_en_i  (cmd_mode_en_i),
        .flush_i    (flush_acc),
        .grant_o    (grant),
        .grant_ch_o (grant_ch),
        .active_o   (active),
        .cur_o      (cur),
        .freeze_o   (freeze_o),
        .ch0_busy_o (ch0_busy)
    );

    assign xfer_ack_o = active;
    assign act_ch_o   = active ? cur : '0;

endmodule

// File: rtl/dxr_chk.sv
module dxr_chk
    import dxr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic       row_miss_i,
    input logic       bus_avail_o,
    input logic       proto_err_o,
    input logic       xfer_ack_o,
    input logic [1:0] act_ch_o,
    input logic [3:0] pend_o,
    input logic [3:0] ch_en_o,
    input logic       freeze_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!bus_avail_o && !xfer_ack_o && !freeze_o && !proto_err_o
                 && pend_o == '0 && ch_en_o == '0));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_avail_o) && !$past(row_miss_i)) |=> !bus_avail_o);

    // R5
    proto_src_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |-> ($past(req_i) && $past(req_i, 2)));

    // R9
    freeze_halt_chk: assert property (@(posedge clk) disable iff (rst)
        freeze_o |-> !xfer_ack_o);

    // R10
    lowest_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_ack_o) |-> (act_ch_o == lowest($past(pend_o & ch_en_o))));

    // R11
    idle_id_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_ack_o |-> (act_ch_o == 2'd0));

    // R11
    id_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack_o && $past(xfer_ack_o)) |-> $stable(act_ch_o));

    // R6
    end_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ch_en_o[0]) |-> !($past(xfer_ack_o) && $past(act_ch_o) == 2'd0));

endmodule

bind dma_xreq_cmd dxr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .row_miss_i  (row_miss_i),
    .bus_avail_o (bus_avail_o),
    .proto_err_o (proto_err_o),
    .xfer_ack_o  (xfer_ack_o),
    .act_ch_o    (act_ch_o),
    .pend_o      (pend_o),
    .ch_en_o     (ch_en_o),
    .freeze_o    (freeze_o)
);

// File: tb/sim_dma_xreq_cmd.sv
`timescale 1ns/1ps
module sim_dma_xreq_cmd;

    localparam int PCW = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_i = 1'b0;
    logic [1:0]     cmd_chan_i = '0;
    logic [1:0]     cmd_op_i = '0;
    logic [2:0]     cmd_len_i = '0;
    logic           row_miss_i = 1'b0;
    logic [PCW-1:0] prech_cycles_i = '0;
    logic           cmd_mode_en_i = 1'b0;
    logic [3:0]     ch_en_set_i = '0;
    logic           xfer_done_i = 1'b0;
    logic           bus_avail_o;
    logic           proto_err_o;
    logic           xfer_ack_o;
    logic [1:0]     act_ch_o;
    logic [3:0]     pend_o;
    logic [3:0]     ch_en_o;
    logic           freeze_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dma_xreq_cmd #(.PCW(PCW)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ceq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_i = 1'b0;
        ch_en_set_i = '0;
        xfer_done_i = 1'b0;
        row_miss_i = 1'b0;
        wait_n(3);
        rst = 1'b0;
    endtask

    task automatic send(input int ch, input int op, input int ln, input bit miss);
        @(negedge clk);
        req_i = 1'b1;
        cmd_chan_i = 2'(ch);
        cmd_op_i = 2'(op);
        cmd_len_i = 3'(ln);
        row_miss_i = miss;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic enable(input logic [3:0] m);
        @(negedge clk);
        ch_en_set_i = m;
        @(negedge clk);
        ch_en_set_i = '0;
    endtask

    task automatic finish_xfer();
        @(negedge clk);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        ceq("R1 bus_avail", int'(bus_avail_o), 0);
        ceq("R1 ack", int'(xfer_ack_o), 0);
        ceq("R1 freeze", int'(freeze_o), 0);
        ceq("R1 pend", int'(pend_o), 0);
        ceq("R1 enables", int'(ch_en_o), 0);
    endtask

    task automatic t_normal();
        do_reset();
        send(1, 1, 0, 1'b0);
        @(negedge clk);
        ceq("R2 pulse high", int'(bus_avail_o), 1);
        ceq("R2 pend ch1", int'(pend_o), 4'b0010);
        @(negedge clk);
        ceq("R2 pulse one cycle", int'(bus_avail_o), 0);
        send(3, 3, 5, 1'b0);
        wait_n(2);
        ceq("R2 pend ch3", int'(pend_o), 4'b1010);
        send(0, 2, 5, 1'b0);
        @(negedge clk);
        ceq("R2 near-flush code pulse", int'(bus_avail_o), 1);
        ceq("R2 near-flush code queues ch0", int'(pend_o), 4'b1011);
    endtask

    task automatic t_precharge();
        int highs;
        do_reset();
        prech_cycles_i = 4'd4;
        send(2, 0, 0, 1'b1);
        highs = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (bus_avail_o) highs++;
        end
        ceq("R3 hold length 4", highs, 4);
        prech_cycles_i = 4'd0;
        send(2, 0, 1, 1'b1);
        highs = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (bus_avail_o) highs++;
        end
        ceq("R3 zero length acts as 1", highs, 1);
    endtask

    task automatic t_ignore();
        int highs;
        do_reset();
        prech_cycles_i = 4'd5;
        send(1, 0, 0, 1'b1);
        send(2, 0, 0, 1'b0);
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (bus_avail_o) highs++;
        end
        ceq("R4 no extra bus-available", highs, 3);
        ceq("R4 dropped request not queued", int'(pend_o), 4'b0010);
        row_miss_i = 1'b0;
    endtask

    task automatic t_proto();
        do_reset();
        @(negedge clk);
        req_i = 1'b1;
        cmd_chan_i = 2'd3; cmd_op_i = 2'd0; cmd_len_i = 3'd0;
        row_miss_i = 1'b0;
        @(negedge clk);
        cmd_chan_i = 2'd2;
        @(negedge clk);
        req_i = 1'b0;
        ceq("R5 error pulse", int'(proto_err_o), 1);
        ceq("R5 first command runs", int'(pend_o), 4'b1000);
        @(negedge clk);
        ceq("R5 error one cycle", int'(proto_err_o), 0);
        ceq("R5 second command dropped", int'(pend_o), 4'b1000);
    endtask

    task automatic t_priority();
        do_reset();
        send(3, 0, 0, 1'b0); wait_n(2);
        send(1, 0, 0, 1'b0); wait_n(2);
        send(2, 0, 0, 1'b0); wait_n(2);
        ceq("R10 three pending", int'(pend_o), 4'b1110);
        enable(4'b1110);
        ceq("R10 no start before enable seen", int'(xfer_ack_o), 0);
        @(negedge clk);
        ceq("R10 start", int'(xfer_ack_o), 1);
        ceq("R11 lowest is ch1", int'(act_ch_o), 1);
        ceq("R10 granted bit cleared", int'(pend_o), 4'b1100);
        wait_n(2);
        ceq("R10 held until done", int'(xfer_ack_o), 1);
        finish_xfer();
        ceq("R10 idle gap after done", int'(xfer_ack_o), 0);
        ceq("R11 idle id", int'(act_ch_o), 0);
        @(negedge clk);
        ceq("R11 next is ch2", int'(act_ch_o), 2);
        finish_xfer();
        @(negedge clk);
        ceq("R11 next is ch3", int'(act_ch_o), 3);
        ceq("R10 ack for ch3", int'(xfer_ack_o), 1);
        finish_xfer();
        wait_n(2);
        ceq("R10 all served", int'(xfer_ack_o), 0);
    endtask

    task automatic t_end();
        do_reset();
        enable(4'b0001);
        send(0, 0, 0, 1'b0);
        wait_n(2);
        ceq("R10 ch0 running", int'(xfer_ack_o), 1);
        ceq("R11 ch0 id", int'(act_ch_o), 0);
        send(0, 0, 7, 1'b0);
        @(negedge clk);
        ceq("R6 refused: no pulse", int'(bus_avail_o), 0);
        @(negedge clk);
        ceq("R6 refused: enable kept", int'(ch_en_o[0]), 1);
        ceq("R6 refused: transfer continues", int'(xfer_ack_o), 1);
        finish_xfer();
        wait_n(1);
        send(0, 0, 7, 1'b0);
        @(negedge clk);
        ceq("R6 accepted pulse", int'(bus_avail_o), 1);
        ceq("R6 enable cleared", int'(ch_en_o[0]), 0);
        enable(4'b0001);
        ceq("R6 re-enable", int'(ch_en_o[0]), 1);
    endtask

    task automatic t_flush_freeze();
        cmd_mode_en_i = 1'b1;
        do_reset();
        enable(4'b0010);
        send(1, 0, 0, 1'b0);
        wait_n(2);
        ceq("R10 ch1 running", int'(xfer_ack_o), 1);
        send(2, 0, 0, 1'b0);
        wait_n(2);
        ceq("R7 ch2 pending", int'(pend_o), 4'b0100);
        @(negedge clk);
        cmd_mode_en_i = 1'b0;
        @(negedge clk);
        ceq("R9 freeze set", int'(freeze_o), 1);
        ceq("R9 ack dropped", int'(xfer_ack_o), 0);
        enable(4'b0100);
        wait_n(3);
        ceq("R9 no start while frozen", int'(xfer_ack_o), 0);
        send(0, 2, 6, 1'b0);
        @(negedge clk);
        ceq("R7 flush pulse", int'(bus_avail_o), 1);
        ceq("R7 queues cleared", int'(pend_o), 0);
        ceq("R8 freeze kept with mode 0", int'(freeze_o), 1);
        @(negedge clk);
        cmd_mode_en_i = 1'b1;
        wait_n(2);
        ceq("R9 idle mode change no effect", int'(freeze_o), 1);
        send(0, 2, 6, 1'b0);
        @(negedge clk);
        ceq("R8 freeze cleared with mode 1", int'(freeze_o), 0);
    endtask

    task automatic t_onedeep();
        do_reset();
        send(2, 1, 0, 1'b0); wait_n(2);
        send(2, 1, 0, 1'b0); wait_n(2);
        ceq("R12 single pending bit", int'(pend_o), 4'b0100);
        enable(4'b0100);
        @(negedge clk);
        ceq("R12 first transfer", int'(xfer_ack_o), 1);
        finish_xfer();
        wait_n(3);
        ceq("R12 no second transfer", int'(xfer_ack_o), 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_normal();
        t_precharge();
        t_ignore();
        t_proto();
        t_priority();
        t_end();
        t_flush_freeze();
        t_onedeep();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
        end
    end

endmodule